// File: doc/BRIEF.md
# Predictable Four-Way Instruction Cache

This block sits between a processor's instruction fetch port and a slower external memory. It holds recently fetched words in a 4-way set-associative array with 32-byte lines and true least-recently-used replacement. A hit is answered on the cycle after the fetch is accepted. On a miss, one burst request asks memory for the words from the missing word through to the end of its line. Every word is forwarded to the fetch port in the cycle it arrives and is also written into the line.

Several features make fetch timing easier to bound. A freeze input keeps the array exactly as it is, which is useful during interrupt handling. A lock flag travels with a fetch and pins that line against eviction. A flush command invalidates and unlocks every line, one set per cycle. An enable input, when low, sends every fetch straight to memory. Each line tracks validity per word, because a fill can start in the middle of a line.

Top module: `icache_pred`

## Requirements
- R1: After reset, `f_ready` stays low for exactly SETS cycles, and `f_rvalid` and `mem_req` stay low. After that, every line is invalid, unlocked and holds no data.
- R2: Hit timing and address fields. A fetch that hits is answered with its address and word in the cycle after acceptance, and it issues no memory request. The byte address splits into fields: the word offset is bits [4:2], the set index sits just above it (bits [9:5] by default), and the tag takes the remaining upper bits.
- R3: On a miss, exactly one `mem_req` is issued in the acceptance cycle. Its `mem_addr` is the fetch address and its `mem_len` is the word count through the end of the line. Each returned word appears on `f_rvalid`/`f_raddr`/`f_rdata` in the cycle it arrives on `mem_rvalid`. `f_ready` stays low until the last word of the burst.
- R4: Validity is tracked per word. A fetch to a word of a resident line that has not yet been filled is a miss. That miss fills the line from the fetched word onward, into the same way.
- R5: The victim on an allocating miss is the least recently used unlocked way of the set. Both hits and allocations make a way most recent.
- R6: While `freeze` is high, hits are served but LRU order is not changed. Misses are streamed from memory without writing tag, data or valid state, and the line can be fetched again only through memory.
- R7: If `f_lock` is high with an accepted fetch, the line that hits, or the line allocated by the miss, becomes locked. A locked line is never chosen as a victim. A lock request is ignored while frozen or bypassed.
- R8: If all four ways of a set are locked, a miss in that set is streamed from memory without allocation.
- R9: A one-cycle `flush_req` pulse holds `f_ready` low for exactly SETS cycles. Afterwards every line is invalid and unlocked. A pulse that arrives during a fill is remembered and carried out once the fill ends.
- R10: While `en` is low, every fetch is treated as a miss and streamed from memory. Tags, data, valid bits and LRU order are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Cache enable; low bypasses the array |
| freeze | input | 1 | Hold array contents and LRU order |
| flush_req | input | 1 | Invalidate and unlock all lines |
| f_valid | input | 1 | Fetch request valid |
| f_lock | input | 1 | Lock the line this fetch hits or allocates |
| f_addr | input | AW | Fetch byte address (word aligned) |
| f_ready | output | 1 | Fetch can be accepted |
| f_rvalid | output | 1 | Returned word valid |
| f_raddr | output | AW | Address of returned word |
| f_rdata | output | DW | Returned instruction word |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | AW | First word address of the burst |
| mem_len | output | OB+1 | Number of words in the burst |
| mem_rvalid | input | 1 | Memory word valid |
| mem_rdata | input | DW | Memory word |

## Verification
The assertions rely on a few properties of the block's inputs. Fetch addresses are word aligned. Memory answers each `mem_req` with exactly `mem_len` words at ascending addresses. `mem_rvalid` never rises outside a burst. The bench's memory model meets all three conditions: it only drives words after it captures a request and stops once the count is used up. The driver issues one fetch at a time and waits for the expected words to drain before issuing the next.

// File: rtl/icache_pred.sv
module icache_pred #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int CAP_BYTES  = 4096,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              freeze,
  input  logic              flush_req,
  input  logic              f_valid,
  input  logic              f_lock,
  input  logic [AW-1:0]     f_addr,
  output logic              f_ready,
  output logic              f_rvalid,
  output logic [AW-1:0]     f_raddr,
  output logic [DW-1:0]     f_rdata,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  output logic [$clog2(LINE_BYTES/(DW/8)):0] mem_len,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata
);
  localparam int WAYS = 4;
  localparam int WB   = DW / 8;
  localparam int WPL  = LINE_BYTES / WB;
  localparam int OB   = $clog2(WPL);
  localparam int BB   = $clog2(WB);
  localparam int SETS = CAP_BYTES / (LINE_BYTES * WAYS);
  localparam int IB   = $clog2(SETS);
  localparam int TB   = AW - IB - OB - BB;
  localparam int LW   = OB + 1;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_FLUSH} st_t;

  logic [TB-1:0]   tag_q [SETS][WAYS];
  logic [WPL-1:0]  wv_q  [SETS][WAYS];
  logic [1:0]      age_q [SETS][WAYS];
  logic [WAYS-1:0] lk_q  [SETS];
  logic [DW-1:0]   dat_q [SETS*WAYS*WPL];

  st_t            st;
  logic [IB-1:0]  fl_idx;
  logic           fl_pend;
  logic           hv_q;
  logic [AW-1:0]  ha_q, fa_q;
  logic [DW-1:0]  hd_q;
  logic [IB-1:0]  fs_q;
  logic [1:0]     fw_q;
  logic [OB-1:0]  fo_q;
  logic           fal_q;

  wire [OB-1:0] a_w = f_addr[BB +: OB];
  wire [IB-1:0] a_s = f_addr[BB+OB +: IB];
  wire [TB-1:0] a_t = f_addr[AW-1 -: TB];

  logic [WAYS-1:0] tmatch;
  logic [1:0]      mway, vic, tw;
  logic            vok, hit, tm_any, alloc, accept, do_touch;

  always_comb begin
    mway = '0;
    vok  = 1'b0;
    vic  = '0;
    for (int w = 0; w < WAYS; w++) begin
      tmatch[w] = (wv_q[a_s][w] != '0) && (tag_q[a_s][w] == a_t);
      if (tmatch[w]) mway = 2'(w);
      if (!lk_q[a_s][w] && (!vok || age_q[a_s][w] > age_q[a_s][vic])) begin
        vok = 1'b1;
        vic = 2'(w);
      end
    end
  end

  assign tm_any   = |tmatch;
  assign hit      = en && tm_any && wv_q[a_s][mway][a_w];
  assign alloc    = en && !freeze && (tm_any || vok);
  assign tw       = tm_any ? mway : vic;
  assign f_ready  = (st == S_IDLE) && !flush_req && !fl_pend;
  assign accept   = f_valid && f_ready;
  assign do_touch = accept && en && !freeze && (hit || alloc);

  assign mem_req  = accept && !hit;
  assign mem_addr = f_addr;
  assign mem_len  = LW'(WPL) - LW'(a_w);

  assign f_rvalid = hv_q || ((st == S_FILL) && mem_rvalid);
  assign f_raddr  = (st == S_FILL) ? fa_q : ha_q;
  assign f_rdata  = (st == S_FILL) ? mem_rdata : hd_q;

  always_ff @(posedge clk) begin
    if (st == S_FLUSH) begin
      lk_q[fl_idx] <= '0;
      for (int w = 0; w < WAYS; w++) begin
        wv_q[fl_idx][w]  <= '0;
        age_q[fl_idx][w] <= 2'(w);
      end
    end else if (st == S_IDLE) begin
      if (do_touch) begin
        for (int v = 0; v < WAYS; v++)
          if (2'(v) == tw) age_q[a_s][v] <= '0;
          else if (age_q[a_s][v] < age_q[a_s][tw]) age_q[a_s][v] <= age_q[a_s][v] + 2'd1;
        if (f_lock) lk_q[a_s][tw] <= 1'b1;
        if (!hit && !tm_any) begin
          tag_q[a_s][tw] <= a_t;
          wv_q[a_s][tw]  <= '0;
        end
      end
    end else if (mem_rvalid && fal_q) begin
      dat_q[{fs_q, fw_q, fo_q}] <= mem_rdata;
      wv_q[fs_q][fw_q][fo_q]    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_FLUSH; fl_idx <= '0; fl_pend <= 1'b0;
      hv_q <= 1'b0; ha_q <= '0; hd_q <= '0;
      fa_q <= '0; fs_q <= '0; fw_q <= '0; fo_q <= '0; fal_q <= 1'b0;
    end else begin
      hv_q <= accept && hit;
      if (accept && hit) begin
        ha_q <= f_addr;
        hd_q <= dat_q[{a_s, mway, a_w}];
      end
      case (st)
        S_FLUSH: begin
          fl_pend <= 1'b0;
          fl_idx  <= fl_idx + IB'(1);
          if (fl_idx == IB'(SETS-1)) st <= S_IDLE;
        end
        S_IDLE: begin
          if (flush_req || fl_pend) begin
            st <= S_FLUSH; fl_idx <= '0; fl_pend <= 1'b0;
          end else if (accept && !hit) begin
            st <= S_FILL; fs_q <= a_s; fw_q <= tw; fo_q <= a_w;
            fal_q <= alloc; fa_q <= f_addr;
          end
        end
        default: begin
          fl_pend <= fl_pend || flush_req;
          if (mem_rvalid) begin
            fo_q <= fo_q + OB'(1);
            fa_q <= fa_q + AW'(WB);
            if (fo_q == OB'(WPL-1)) st <= S_IDLE;
          end
        end
      endcase
    end
  end

  logic [IB-1:0] chk_s_q;
  always_ff @(posedge clk) chk_s_q <= a_s;
  wire [7:0] age_cur = {age_q[a_s][3], age_q[a_s][2], age_q[a_s][1], age_q[a_s][0]};
  wire [7:0] age_chk = {age_q[chk_s_q][3], age_q[chk_s_q][2], age_q[chk_s_q][1], age_q[chk_s_q][0]};

  a_r2_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> (f_rvalid && f_raddr == $past(f_addr)));
  a_r3_forward: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_FILL) && mem_rvalid) |-> (f_rvalid && f_rdata == mem_rdata));
  a_r5_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> $onehot0(tmatch));
  a_r7_no_locked_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit && alloc && !tm_any) |-> !lk_q[a_s][tw]);
  a_r6_frozen_lru: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && freeze) |=> (age_chk == $past(age_cur)));
endmodule

// File: tb/icache_pred_tb.sv
module icache_pred_tb;
  localparam int SETS = 32;
  localparam int MEM_LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, freeze = 1'b0, flush_req = 1'b0;
  logic f_valid = 1'b0, f_lock = 1'b0;
  logic [31:0] f_addr = '0;
  logic f_ready, f_rvalid, mem_req;
  logic [31:0] f_raddr, f_rdata, mem_addr;
  logic [3:0] mem_len;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  icache_pred u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .freeze(freeze), .flush_req(flush_req),
    .f_valid(f_valid), .f_lock(f_lock), .f_addr(f_addr), .f_ready(f_ready),
    .f_rvalid(f_rvalid), .f_raddr(f_raddr), .f_rdata(f_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  int checks = 0, failures = 0, mreq = 0;
  bit done = 1'b0;
  string cur = "R3";
  logic [31:0] qa[$], qd[$];

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h1234_5678;
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  logic [31:0] mptr = '0;
  int mleft = 0, mwait = 0;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mleft != 0) begin
      if (mwait != 0) mwait <= mwait - 1;
      else begin
        mem_rvalid <= 1'b1; mem_rdata <= mdata(mptr);
        mptr <= mptr + 4; mleft <= mleft - 1;
      end
    end
    if (mem_req) begin
      mreq++;
      mptr <= mem_addr; mleft <= int'(mem_len); mwait <= MEM_LAT - 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && f_rvalid) begin
      if (qa.size() == 0) chk(1'b0, {cur, " unexpected word"}, f_raddr, 0);
      else begin
        logic [31:0] ea, ed;
        ea = qa.pop_front(); ed = qd.pop_front();
        chk(f_raddr == ea, {cur, " word address"}, f_raddr, ea);
        chk(f_rdata == ed, {cur, " word data"}, f_rdata, ed);
      end
    end
  end

  task automatic fetch(input logic [31:0] a, input bit exp_hit, input bit lk, input string rq);
    int m0, k;
    m0 = mreq;
    if (exp_hit) begin qa.push_back(a); qd.push_back(mdata(a)); end
    else for (logic [31:0] x = a; x[4:0] != 5'd0 || x == a; x += 4) begin
      qa.push_back(x); qd.push_back(mdata(x));
    end
    @(negedge clk);
    cur = rq; f_valid = 1'b1; f_addr = a; f_lock = lk;
    while (!f_ready) @(negedge clk);
    @(negedge clk);
    f_valid = 1'b0; f_lock = 1'b0;
    k = 1;
    while (!f_rvalid && k < 60) begin @(negedge clk); k++; end
    chk(k == (exp_hit ? 1 : MEM_LAT + 1), {rq, " first word latency"}, k, exp_hit ? 1 : MEM_LAT + 1);
    while (qa.size() != 0 && k < 80) begin @(negedge clk); k++; end
    chk(mreq - m0 == (exp_hit ? 0 : 1), {rq, " memory requests"}, mreq - m0, exp_hit ? 0 : 1);
  endtask

  task automatic ready_gap(input string rq);
    int n = 0;
    while (!f_ready && n < 1000) begin
      chk(!f_rvalid && !mem_req, {rq, " quiet while busy"}, f_rvalid, 0);
      n++; @(negedge clk);
    end
    chk(n == SETS, {rq, " ready low cycles"}, n, SETS);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!f_rvalid && !mem_req && !f_ready, "R1 reset outputs", f_rvalid, 0);
    rst_n = 1'b1;
    ready_gap("R1");
    fetch(32'h100, 0, 0, "R1 cold miss");
    // R3 streaming miss and R2 hits
    fetch(32'h104, 1, 0, "R2");
    fetch(32'h11C, 1, 0, "R2");
    // R4 partial lines
    fetch(32'h214, 0, 0, "R4");
    fetch(32'h218, 1, 0, "R4");
    fetch(32'h208, 0, 0, "R4");
    fetch(32'h200, 0, 0, "R4");
    fetch(32'h200, 1, 0, "R4");
    fetch(32'h20C, 1, 0, "R4");
    // R5 LRU in set 3
    fetch(32'h060, 0, 0, "R5"); fetch(32'h460, 0, 0, "R5");
    fetch(32'h860, 0, 0, "R5"); fetch(32'hC60, 0, 0, "R5");
    fetch(32'h060, 1, 0, "R5"); fetch(32'h1060, 0, 0, "R5");
    fetch(32'h060, 1, 0, "R5"); fetch(32'h860, 1, 0, "R5");
    fetch(32'hC60, 1, 0, "R5"); fetch(32'h1060, 1, 0, "R5");
    fetch(32'h460, 0, 0, "R5"); fetch(32'h060, 0, 0, "R5");
    // R6 freeze
    freeze = 1'b1;
    fetch(32'h300, 0, 0, "R6"); fetch(32'h300, 0, 0, "R6");
    fetch(32'h104, 1, 0, "R6"); fetch(32'hC60, 1, 0, "R6");
    freeze = 1'b0;
    fetch(32'h1460, 0, 0, "R6"); fetch(32'hC60, 0, 0, "R6");
    fetch(32'h060, 1, 0, "R6");
    // R7 lock on miss, set 5
    fetch(32'h0A0, 0, 1, "R7"); fetch(32'h4A0, 0, 0, "R7");
    fetch(32'h8A0, 0, 0, "R7"); fetch(32'hCA0, 0, 0, "R7");
    fetch(32'h10A0, 0, 0, "R7"); fetch(32'h0A0, 1, 0, "R7");
    fetch(32'h4A0, 0, 0, "R7");
    // R7 lock on hit, set 9
    fetch(32'h120, 0, 0, "R7"); fetch(32'h520, 0, 0, "R7");
    fetch(32'h920, 0, 0, "R7"); fetch(32'hD20, 0, 0, "R7");
    fetch(32'h120, 1, 1, "R7"); fetch(32'h520, 1, 0, "R7");
    fetch(32'h920, 1, 0, "R7"); fetch(32'hD20, 1, 0, "R7");
    fetch(32'h1120, 0, 0, "R7"); fetch(32'h120, 1, 0, "R7");
    fetch(32'h520, 0, 0, "R7");
    // R8 whole set locked, set 7
    fetch(32'h0E0, 0, 1, "R8"); fetch(32'h4E0, 0, 1, "R8");
    fetch(32'h8E0, 0, 1, "R8"); fetch(32'hCE0, 0, 1, "R8");
    fetch(32'h10E0, 0, 0, "R8"); fetch(32'h10E0, 0, 0, "R8");
    fetch(32'h0E0, 1, 0, "R8"); fetch(32'h4E0, 1, 0, "R8");
    // R9 flush
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    ready_gap("R9");
    fetch(32'h104, 0, 0, "R9");
    fetch(32'h0E0, 0, 0, "R9"); fetch(32'h4E0, 0, 0, "R9");
    fetch(32'h8E0, 0, 0, "R9"); fetch(32'hCE0, 0, 0, "R9");
    fetch(32'h10E0, 0, 0, "R9"); fetch(32'h0E0, 0, 0, "R9");
    // R10 bypass
    en = 1'b0;
    fetch(32'h104, 0, 0, "R10"); fetch(32'h600, 0, 0, "R10");
    en = 1'b1;
    fetch(32'h600, 0, 0, "R10"); fetch(32'h104, 1, 0, "R10");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule